// File: doc/BRIEF.md
# Framebuffer Fill Engine

This block fills a run of words in a word-addressed framebuffer with one repeated 16-bit value. Software programs a length and a start address, then writes the fill value. That last write both stores the value and launches the fill. The engine then emits one memory write per clock until the run is complete.

The framebuffer is double buffered. A frame-select input names the buffer that is currently being displayed, and the fill always goes to the other one. Address sequencing is confined to a 256-word block. Only the low byte of the address advances, and it wraps, while the upper byte stays where it was. When the fill ends, the start-address register holds the address that follows the last word written. A second fill can therefore continue from where the first one stopped.

Top module: `fb_fill_engine`

## Requirements
- R1: After reset, busy and mem_we are 0, and the length, start and data registers all read back as 0.
- R2: Register select uses these codes: 0 is length, 1 is start address and 2 is fill data. A write with select 2 while the engine is idle stores the value, which then reads back with rd_sel 2. It also starts the fill, and the first word appears on the memory port in the cycle after the write.
- R3: A fill writes exactly length+1 words, one per clock, with mem_we held high in every one of those cycles. A length of 0 gives 1 word, and a length of 255 gives 256 words.
- R4: The first word goes to the start address. Each later word adds 1 to address bits [7:0], wrapping from 255 to 0. Address bits [15:8] do not change.
- R5: When busy falls, the start register reads back the address that follows the last word written, computed with the same low-byte wrap.
- R6: mem_bank equals the inverse of frame_sel sampled at the triggering write. It stays constant for the whole fill, even if frame_sel changes.
- R7: A write with select 1 only loads the start register. No memory write takes place and busy stays 0.
- R8: A write with select 0 only loads the 8-bit length register. No memory write takes place and busy stays 0.
- R9: While busy is 1, register writes of any select are ignored. No register value changes and the fill continues undisturbed.
- R10: mem_wdata equals the stored fill value in every cycle in which mem_we is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for writes (0 length, 1 start, 2 data) |
| reg_wdata | input | 16 | Register write data |
| rd_sel | input | 2 | Register select for read-back |
| rd_data | output | 16 | Read-back value (length zero-extended; select 3 returns 0) |
| frame_sel | input | 1 | Buffer currently displayed |
| busy | output | 1 | Fill in progress |
| mem_we | output | 1 | Memory write enable |
| mem_bank | output | 1 | Target buffer of the write |
| mem_addr | output | 16 | Word address of the write |
| mem_wdata | output | 16 | Data of the write |

## Verification
The bench runs fills over several patterns, and each one isolates a different part of the behaviour:
- A single-word fill with length 0 exposes off-by-one errors in the word count.
- A fill whose start low byte is near 255 exposes carries that leak into the upper address byte.
- A full 256-word fill shows that the address wraps back to the start and that the final start register equals the original start.
- Fills run with each frame_sel value, and frame_sel is toggled mid-fill, to tell a latched bank apart from a live one.
- Writes to every register during a fill separate ignored writes from writes that take effect.

// File: rtl/fb_fill_engine.sv
module fb_fill_engine #(
  parameter int AW     = 16,
  parameter int DW     = 16,
  parameter int LW     = 8,
  parameter int WRAP_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  input  logic [1:0]    rd_sel,
  output logic [DW-1:0] rd_data,
  input  logic          frame_sel,
  output logic          busy,
  output logic          mem_we,
  output logic          mem_bank,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  localparam logic [1:0] SEL_LEN = 2'd0, SEL_START = 2'd1, SEL_DATA = 2'd2;

  logic [LW-1:0] len_q, left_q;
  logic [AW-1:0] start_q;
  logic [DW-1:0] data_q;
  logic          bank_q, busy_q;

  wire           accept  = reg_wr && !busy_q;
  wire [AW-1:0]  next_ad = {start_q[AW-1:WRAP_W], start_q[WRAP_W-1:0] + 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q   <= '0;
      left_q  <= '0;
      start_q <= '0;
      data_q  <= '0;
      bank_q  <= 1'b0;
      busy_q  <= 1'b0;
    end else if (busy_q) begin
      start_q <= next_ad;
      if (left_q == '0) busy_q <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end else if (accept) begin
      case (reg_sel)
        SEL_LEN:   len_q   <= reg_wdata[LW-1:0];
        SEL_START: start_q <= reg_wdata[AW-1:0];
        SEL_DATA: begin
          data_q <= reg_wdata;
          left_q <= len_q;
          bank_q <= ~frame_sel;
          busy_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign busy      = busy_q;
  assign mem_we    = busy_q;
  assign mem_bank  = bank_q;
  assign mem_addr  = start_q;
  assign mem_wdata = data_q;

  always_comb begin
    case (rd_sel)
      SEL_LEN:   rd_data = DW'(len_q);
      SEL_START: rd_data = DW'(start_q);
      SEL_DATA:  rd_data = data_q;
      default:   rd_data = '0;
    endcase
  end

  a_r2_trigger_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_DATA && !busy) |=> (busy && mem_we));

  a_r6_bank_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_DATA && !busy) |=> (mem_bank == !$past(frame_sel)));

  a_r6_bank_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_bank));

  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |->
      (mem_addr[AW-1:WRAP_W] == $past(mem_addr[AW-1:WRAP_W]) &&
       mem_addr[WRAP_W-1:0] == WRAP_W'($past(mem_addr[WRAP_W-1:0]) + 1'b1)));

  a_r10_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_wdata));

  a_r9_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr) |=> ($stable(len_q) && $stable(data_q)));

  a_r7_start_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_wr && reg_sel != SEL_DATA) |=> !mem_we);
endmodule

// File: tb/fb_fill_engine_bench.sv
module fb_fill_engine_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, frame_sel = 1'b0;
  logic [1:0]  reg_sel = '0, rd_sel = '0;
  logic [15:0] reg_wdata = '0, rd_data, mem_addr, mem_wdata;
  logic        busy, mem_we, mem_bank;
  int          n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fb_fill_engine u_fb_fill_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .rd_sel(rd_sel), .rd_data(rd_data),
    .frame_sel(frame_sel), .busy(busy), .mem_we(mem_we),
    .mem_bank(mem_bank), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  function automatic logic [15:0] step(input logic [15:0] a);
    return {a[15:8], a[7:0] + 8'd1};
  endfunction

  task automatic readback(input logic [1:0] sel, input logic [15:0] exp, input string req);
    rd_sel = sel; #1;
    check(req, rd_data, exp);
  endtask

  // Runs one fill and checks every word; optionally disturbs it mid-way.
  task automatic run_fill(input logic [7:0] len, input logic [15:0] start,
                          input logic [15:0] data, input logic fs, input bit disturb);
    int words = 0, bad_addr = 0, bad_data = 0, bad_bank = 0;
    logic [15:0] exp_a = start;
    wr(2'd0, {8'hA5, len});
    wr(2'd1, start);
    frame_sel = fs;
    wr(2'd2, data);
    check("R2 busy after data write", busy, 1'b1);
    readback(2'd2, data, "R2 data readback");
    while (busy && words < 400) begin
      if (!mem_we) bad_addr++;
      if (mem_addr !== exp_a) bad_addr++;
      if (mem_wdata !== data) bad_data++;
      if (mem_bank !== !fs) bad_bank++;
      exp_a = step(exp_a);
      words++;
      if (disturb && words == 2) begin
        frame_sel = !fs;
        reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 16'h0003;
        @(negedge clk);
        if (mem_addr !== exp_a) bad_addr++;
        exp_a = step(exp_a); words++;
        reg_sel = 2'd1; reg_wdata = 16'h1234;
        @(negedge clk);
        if (mem_addr !== exp_a) bad_addr++;
        exp_a = step(exp_a); words++;
        reg_sel = 2'd2; reg_wdata = 16'hDEAD;
        @(negedge clk);
        reg_wr = 1'b0;
        continue;
      end
      @(negedge clk);
    end
    check("R3 word count", words, 32'(len) + 1);
    check("R4 address sequence mismatches", bad_addr, 0);
    check("R10 data mismatches", bad_data, 0);
    check("R6 bank mismatches", bad_bank, 0);
    check("R3 mem_we low after fill", mem_we, 1'b0);
    readback(2'd1, exp_a, "R5 start after fill");
    if (disturb) begin
      readback(2'd0, {8'h00, len}, "R9 length unchanged");
      readback(2'd2, data, "R9 data unchanged");
    end
    frame_sel = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 busy", busy, 1'b0);
    check("R1 mem_we", mem_we, 1'b0);
    readback(2'd0, 16'h0, "R1 length");
    readback(2'd1, 16'h0, "R1 start");
    readback(2'd2, 16'h0, "R1 data");
  endtask

  task automatic t_plain_writes;
    int we_seen = 0;
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = 16'h4C20;
    @(negedge clk);
    if (mem_we || busy) we_seen++;
    reg_sel = 2'd0; reg_wdata = 16'h0007;
    @(negedge clk);
    reg_wr = 1'b0;
    if (mem_we || busy) we_seen++;
    @(negedge clk);
    if (mem_we || busy) we_seen++;
    check("R7 R8 no memory write", we_seen, 0);
    readback(2'd1, 16'h4C20, "R7 start loaded");
    readback(2'd0, 16'h0007, "R8 length loaded");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain_writes();
    run_fill(8'd0,   16'h1234, 16'hBEEF, 1'b0, 1'b0);
    run_fill(8'd9,   16'h20FB, 16'h5A5A, 1'b1, 1'b0);
    run_fill(8'd255, 16'h7710, 16'h0F0F, 1'b0, 1'b0);
    run_fill(8'd12,  16'h03F0, 16'hC3C3, 1'b1, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule